// File: doc/BRIEF.md
# SPI EEPROM Read Sequencer

This block is the serial slave front end that serves read traffic for a 64 KB byte-wide EEPROM array. A transaction opens when the chip select falls. The block collects a command byte from the serial input. For a read command it then collects the start address and streams bytes from the array back on the serial output, most significant bit first, with no gap between bytes. The address advances after every byte and wraps at the top of the array, so one transaction can read the whole array. For a status command it returns the status byte, which the surrounding logic supplies, for as long as the host keeps clocking. Any other command is dropped.

The serial pins use SPI mode 0. The block runs on a faster system clock, so it oversamples the serial pins through a synchronizer and detects the clock edges internally. The array is reached through a synchronous read port with one cycle of latency. Each byte is fetched one serial edge before its first bit has to appear, which gives the array time to answer. Raising chip select ends the transaction at any bit and returns the serial output to high impedance. Programming and write protection are handled elsewhere.

Top module: `spi_eeprom_rd`

## Requirements
- R1: While chip select is high, so_o is high impedance and mem_rd_o stays low. After reset the block is in this idle state.
- R2: The first 8 bits after chip select falls are a command, sampled on rising sck_i, MSB first. Command 0x03 is a read and is followed by ADDR_W address bits, MSB first.
- R3: so_o changes only after a falling sck_i. The first data bit (D7) is driven after the falling edge that follows the last address bit, and the remaining bits follow in the order D7 down to D0.
- R4: While chip select stays low, the byte at the next higher address follows directly after each byte, with no extra clock.
- R5: After the byte at address 0xFFFF, the read continues at address 0x0000.
- R6: Once the address has been received, the value on si_i has no effect on the bytes returned.
- R7: Command 0x05 returns status_i on so_o, MSB first. The status byte is sampled again before each new byte, and it repeats for as long as clocking continues. No array read is issued.
- R8: Any command other than 0x03 or 0x05 leaves so_o high impedance and issues no array read until chip select rises.
- R9: Raising chip select at any bit aborts the transaction. The next transaction starts again from the command phase.
- R10: For each byte streamed, exactly one single-cycle mem_rd_o pulse is issued, carrying that byte's address. A read that streams N bytes issues N+1 pulses, because of the prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than sck_i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host, high impedance when not driving |
| mem_rd_o | output | 1 | Single-cycle read request to the array |
| mem_addr_o | output | ADDR_W | Address of the read request |
| mem_data_i | input | 8 | Array data, valid one clock after the request |
| status_i | input | 8 | Status byte returned by the status command |

## Verification
The bench builds the block with its default values: a 16-bit address and a two-stage synchronizer. The serial clock runs at one sixteenth of the system clock. With the full 16-bit address, the wrap from 0xFFFF to 0x0000 is reached by starting a read two bytes below the top, so the real rollover is exercised instead of a narrowed copy. The serial clock is slow enough that every prefetch completes within half a serial period. This makes the bit timing on so_o exact at the point where a mode-0 host samples it.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_STAT = 8'h05;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_READ,
    PH_STAT,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic act_o,
  output logic rise_o,
  output logic fall_o,
  output logic si_o
);
  logic [STAGES-1:0] sck_sr, cs_sr, si_sr;
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      si_sr  <= '0;
      sck_q  <= 1'b0;
    end else begin
      sck_sr[0] <= sck_i;
      cs_sr[0]  <= cs_ni;
      si_sr[0]  <= si_i;
      for (int i = 1; i < int'(STAGES); i++) begin
        sck_sr[i] <= sck_sr[i-1];
        cs_sr[i]  <= cs_sr[i-1];
        si_sr[i]  <= si_sr[i-1];
      end
      sck_q <= sck_sr[STAGES-1];
    end
  end

  assign act_o  = ~cs_sr[STAGES-1];
  assign rise_o = act_o & sck_sr[STAGES-1] & ~sck_q;
  assign fall_o = act_o & ~sck_sr[STAGES-1] & sck_q;
  assign si_o   = si_sr[STAGES-1];
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              rise_i,
  input  logic              si_i,
  output logic              fetch_o,
  output logic              stat_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CW = $clog2(ADDR_W);

  phase_e            phase_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic [BYTE_W-1:0] cmd_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              byte_end, addr_end;

  assign cmd_nx   = {cmd_q[BYTE_W-2:0], si_i};
  assign addr_nx  = {addr_q[ADDR_W-2:0], si_i};
  assign byte_end = cnt_q == CW'(BYTE_W - 1);
  assign addr_end = cnt_q == CW'(ADDR_W - 1);

  always_comb begin
    fetch_o = 1'b0;
    stat_o  = 1'b0;
    addr_o  = ptr_q;
    if (rise_i) begin
      unique case (phase_q)
        PH_CMD:  if (byte_end && cmd_nx == CMD_STAT) begin
                   fetch_o = 1'b1;
                   stat_o  = 1'b1;
                 end
        PH_ADDR: if (addr_end) begin
                   fetch_o = 1'b1;
                   addr_o  = addr_nx;
                 end
        PH_READ: fetch_o = byte_end;
        PH_STAT: begin
                   fetch_o = byte_end;
                   stat_o  = byte_end;
                 end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      ptr_q   <= '0;
    end else if (!act_i) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
    end else if (rise_i) begin
      unique case (phase_q)
        PH_CMD: begin
          cmd_q <= cmd_nx;
          cnt_q <= byte_end ? '0 : cnt_q + 1'b1;
          if (byte_end) begin
            if (cmd_nx == CMD_READ)      phase_q <= PH_ADDR;
            else if (cmd_nx == CMD_STAT) phase_q <= PH_STAT;
            else                         phase_q <= PH_SKIP;
          end
        end
        PH_ADDR: begin
          addr_q <= addr_nx;
          cnt_q  <= addr_end ? '0 : cnt_q + 1'b1;
          if (addr_end) begin
            phase_q <= PH_READ;
            ptr_q   <= addr_nx + 1'b1;
          end
        end
        PH_READ: begin
          cnt_q <= byte_end ? '0 : cnt_q + 1'b1;
          if (byte_end) ptr_q <= ptr_q + 1'b1;  // wraps at the top
        end
        PH_STAT: cnt_q <= byte_end ? '0 : cnt_q + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx
  import spi_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              fall_i,
  input  logic              fetch_i,
  input  logic              stat_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              so_d_o,
  output logic              so_oe_o
);
  logic              rd_q, stat_q, pend_q, oe_q;
  logic [BYTE_W-1:0] nxt_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      stat_q <= 1'b0;
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
      nxt_q  <= '0;
      sh_q   <= '0;
    end else if (!act_i) begin
      rd_q   <= 1'b0;
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      rd_q   <= fetch_i;
      stat_q <= stat_i;
      // array answers one clock after the request
      if (rd_q) nxt_q <= stat_q ? status_i : mem_data_i;
      if (fetch_i) pend_q <= 1'b1;
      if (fall_i) begin
        if (pend_q) begin
          sh_q   <= nxt_q;
          pend_q <= 1'b0;
          oe_q   <= 1'b1;
        end else begin
          sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_d_o  = sh_q[BYTE_W-1];
  assign so_oe_o = oe_q;
endmodule

// File: rtl/spi_eeprom_rd.sv
module spi_eeprom_rd
  import spi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  input  logic [7:0]        status_i
);
  logic act, sck_rise, sck_fall, si_s;
  logic fetch, fetch_stat, so_d, so_oe;

  spi_rd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .act_o(act), .rise_o(sck_rise), .fall_o(sck_fall), .si_o(si_s)
  );

  spi_rd_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i, .rst_ni, .act_i(act), .rise_i(sck_rise), .si_i(si_s),
    .fetch_o(fetch), .stat_o(fetch_stat), .addr_o(mem_addr_o)
  );

  spi_rd_tx i_tx (
    .clk_i, .rst_ni, .act_i(act), .fall_i(sck_fall),
    .fetch_i(fetch), .stat_i(fetch_stat),
    .mem_data_i, .status_i,
    .so_d_o(so_d), .so_oe_o(so_oe)
  );

  assign mem_rd_o = fetch & ~fetch_stat;
  assign so_o     = so_oe ? so_d : 1'bz;
endmodule

// File: rtl/spi_rd_chk.sv
module spi_rd_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              act_i,
  input logic              fall_i,
  input logic              so_i,
  input logic              mem_rd_i,
  input logic [ADDR_W-1:0] mem_addr_i
);
  logic [ADDR_W-1:0] last_q;
  logic              have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (!act_i) begin
      have_q <= 1'b0;
    end else if (mem_rd_i) begin
      last_q <= mem_addr_i;
      have_q <= 1'b1;
    end
  end

  // R1
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |-> !mem_rd_i);

  // R10
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |=> !mem_rd_i);

  // R4 R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i && have_q |-> mem_addr_i == ADDR_W'(last_q + 1'b1));

  // R3
  so_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && $past(act_i) && (so_i !== $past(so_i)) |-> $past(fall_i));
endmodule

bind spi_eeprom_rd spi_rd_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .fall_i(sck_fall),
  .so_i(so_o), .mem_rd_i(mem_rd_o), .mem_addr_i(mem_addr_o)
);

// File: tb/test_spi_eeprom_rd.sv
`timescale 1ns/1ps
module test_spi_eeprom_rd;
  localparam int AW = 16;
  localparam int HALF = 8;  // system clocks per sck half period

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic          so, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data = '0, status = 8'hA5;
  int            n_run = 0, n_fail = 0, rd_cnt = 0;

  always #2.5 clk = ~clk;

  spi_eeprom_rd i_spi_eeprom_rd (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .status_i(status)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= pat(mem_addr);
      rd_cnt   <= rd_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      wait_clk(HALF);
      rx[b] = so;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic start_read(input logic [AW-1:0] a);
    logic [7:0] rx;
    cs_low();
    spi_byte(8'h03, rx);
    spi_byte(a[15:8], rx);
    spi_byte(a[7:0], rx);
  endtask

  task automatic t_reset();
    check("R1 so idle", {7'd0, so}, {7'd0, 1'bz});
    check("R1 no reads", 8'(rd_cnt), 8'd0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input int n, input logic [7:0] si_fill, input string req);
    logic [7:0] rx;
    int c0;
    c0 = rd_cnt;
    start_read(a);
    for (int i = 0; i < n; i++) begin
      spi_byte(si_fill ^ 8'(i * 37), rx);
      check(req, rx, pat(AW'(a + AW'(i))));
    end
    cs_high();
    check("R10 read count", 8'(rd_cnt - c0), 8'(n + 1));
    check("R1 so idle after read", {7'd0, so}, {7'd0, 1'bz});
  endtask

  task automatic t_status();
    logic [7:0] rx;
    int c0;
    c0 = rd_cnt;
    status = 8'hA5;
    cs_low();
    spi_byte(8'h05, rx);
    spi_byte(8'hFF, rx);
    check("R7 status byte0", rx, 8'hA5);
    status = 8'h3C;
    spi_byte(8'h00, rx);
    check("R7 status byte1 prefetched", rx, 8'hA5);
    spi_byte(8'h03, rx);
    check("R7 status byte2 resampled", rx, 8'h3C);
    cs_high();
    check("R7 no array read", 8'(rd_cnt - c0), 8'd0);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] rx;
    int c0;
    c0 = rd_cnt;
    cs_low();
    spi_byte(8'h9F, rx);
    for (int i = 0; i < 3; i++) begin
      spi_byte(8'h03, rx);
      check("R8 so stays z", rx, 8'hzz);
    end
    cs_high();
    check("R8 no array read", 8'(rd_cnt - c0), 8'd0);
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    // abort inside address phase
    cs_low();
    spi_byte(8'h03, rx);
    for (int b = 0; b < 5; b++) begin
      si = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    cs_high();
    check("R9 so z after addr abort", {7'd0, so}, {7'd0, 1'bz});
    // abort inside data byte
    start_read(16'h0100);
    for (int b = 0; b < 3; b++) begin
      wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    cs_high();
    check("R9 so z after data abort", {7'd0, so}, {7'd0, 1'bz});
    t_read(16'h0200, 2, 8'h00, "R9 fresh read after abort");
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_read(16'h1234, 4, 8'h00, "R2 R3 R4 sequential data");
    t_read(16'hFFFE, 4, 8'h00, "R5 wrap");
    t_read(16'h00A0, 3, 8'hFF, "R6 si ignored");
    t_read(16'h7F00, 2, 8'h03, "R6 si ignored with command pattern");
    t_status();
    t_bad_cmd();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule